// File: doc/BRIEF.md
# Parallel Priority Interrupt Controller

The block collects interrupt requests from a small set of sources and decides which one the processor should service first. A source records a request when its input goes from low to high. The recorded bit stays set until software clears it, even after the source has gone quiet. A per-source enable bit selects which recorded requests count. A fixed-priority encoder turns the enabled requests into a binary source code, and the lowest source index wins.

A summary flag is set while any enabled request is pending. The processor interrupt line is that flag gated by a global enable. Software turns the global enable on and off with two separate command pulses, and the block turns it off by itself when an interrupt cycle begins. When the processor raises acknowledge, the block captures the winning code once, at the first clock of the acknowledge. From the next clock it drives a vector byte that holds that code in its low bits and zeros above. The byte stays constant until acknowledge falls, and the bus output is released outside acknowledge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt line is low, the bus output enable is low and the bus value is zero; every recorded request, every per-source enable bit and the global enable start at 0.
- R2: A recorded request bit is set at the clock that sees its source input high after it was low at the previous clock. It stays set after the input falls. A source held high sets it again only after the input has fallen and risen again.
- R3: Asserting bit i of the clear input for one clock clears only recorded request i; if source i rises in that same clock, the bit ends up set.
- R4: A write strobe loads the whole per-source enable register from the write data (bit i = 1 enables source i); a recorded request whose enable bit is 0 never raises the interrupt line or takes part in priority.
- R5: Among the enabled recorded requests the lowest index wins and is coded in binary: source 0 gives code 0 (00), source 1 gives 01, source 2 gives 10, source 3 gives 11.
- R6: The interrupt line is high exactly when the global enable is 1 and at least one enabled recorded request is pending.
- R7: An enable-on pulse sets the global enable at the next clock and an enable-off pulse clears it; when both arrive in the same clock, the enable ends up cleared.
- R8: The first clock with acknowledge high (after a clock with it low) clears the global enable, so the interrupt line is low from the following clock; this beats a simultaneous enable-on pulse.
- R9: At the first clock of acknowledge the winning code is captured. From the next clock the output enable is 1 and the bus carries the code in bits [1:0] with all upper bits zero. The bus value stays unchanged for as long as acknowledge stays high, even if new requests arrive.
- R10: At the clock after acknowledge is seen low, the output enable returns to 0 and the bus value reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Source request lines, bit 0 highest priority |
| pend_clr_i | input | NUM_SRC | Per-source clear strobes for recorded requests |
| mask_wr_i | input | 1 | Write strobe for the per-source enable register |
| mask_wdata_i | input | NUM_SRC | New per-source enable value, 1 = enabled |
| ien_on_i | input | 1 | Global enable on command |
| ien_off_i | input | 1 | Global enable off command |
| ack_i | input | 1 | Processor interrupt acknowledge |
| int_o | output | 1 | Interrupt request to the processor |
| vec_oe_o | output | 1 | Bus drive enable, 0 = released |
| vec_o | output | BUS_W | Vector byte value |

## Verification
A recorded request bit that is wrong shows up at the interrupt line in the clock after the global enable is turned on. It also shows up in the vector's low bits one clock after acknowledge. To expose it, the bench sweeps every combination of pending and enabled sources, so each bit appears at the ports within a few clocks. A wrong global enable shows at the interrupt line straight away, because that line is pure gating of registers. A capture that is wrong or lost shows as the bus changing while acknowledge is still high, or as the drive enable lingering one clock after acknowledge falls.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      IEN_KEEP  = 2'd0,
      IEN_RAISE = 2'd1,
      IEN_DROP  = 2'd2
   } ien_cmd_t;

   function automatic ien_cmd_t ien_decode(input logic on_c, input logic off_c,
                                           input logic take_c);
      if (take_c || off_c) return IEN_DROP;
      if (on_c)            return IEN_RAISE;
      return IEN_KEEP;
   endfunction
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);
   logic [NUM_SRC-1:0] req_q;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic rise;
      assign rise = req_i[g] & ~req_q[g];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            req_q[g]  <= 1'b0;
            pend_o[g] <= 1'b0;
         end else begin
            req_q[g] <= req_i[g];
            if (rise)          pend_o[g] <= 1'b1;
            else if (clr_i[g]) pend_o[g] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_SRC = 4,
   parameter int CODE_W  = 2
) (
   input  logic [NUM_SRC-1:0] masked_i,
   output logic [CODE_W-1:0]  code_o,
   output logic               any_o
);
   assign any_o = |masked_i;

   if (NUM_SRC == 4 && CODE_W == 2) begin : g_four
      logic hi_bit, lo_bit;
      assign hi_bit = ~masked_i[0] & ~masked_i[1];
      assign lo_bit = (~masked_i[0] & masked_i[1]) | (~masked_i[0] & ~masked_i[2]);
      assign code_o = {hi_bit, lo_bit};
   end else begin : g_generic
      always_comb begin
         code_o = '1;
         for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (masked_i[i]) code_o = CODE_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_vec_port.sv
module irq_vec_port #(
   parameter int CODE_W = 2,
   parameter int BUS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              take_o,
   output logic              oe_o,
   output logic [BUS_W-1:0]  vec_o
);
   localparam int PAD_W = BUS_W - CODE_W;

   logic [CODE_W-1:0] code_q;

   assign take_o = ack_i & ~oe_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_o   <= 1'b0;
         code_q <= '0;
      end else if (!ack_i) begin
         oe_o <= 1'b0;
      end else if (take_o) begin
         oe_o   <= 1'b1;
         code_q <= code_i;
      end
   end

   assign vec_o = oe_o ? {{PAD_W{1'b0}}, code_q} : '0;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int BUS_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] pend_clr_i,
   input  logic               mask_wr_i,
   input  logic [NUM_SRC-1:0] mask_wdata_i,
   input  logic               ien_on_i,
   input  logic               ien_off_i,
   input  logic               ack_i,
   output logic               int_o,
   output logic               vec_oe_o,
   output logic [BUS_W-1:0]   vec_o
);
   localparam int CODE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 2) begin : g_bad_src
      $error("prio_irq_ctrl: NUM_SRC must be at least 2");
   end
   if (BUS_W <= CODE_W) begin : g_bad_bus
      $error("prio_irq_ctrl: BUS_W must exceed the code width");
   end

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] masked;
   logic [CODE_W-1:0]  code;
   logic               ist;
   logic               ien_q;
   logic               take;
   ien_cmd_t           ien_cmd;

   irq_pend_reg #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .clr_i  (pend_clr_i),
      .pend_o (pend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         mask_q <= '0;
      else if (mask_wr_i) mask_q <= mask_wdata_i;
   end

   assign masked = pend & mask_q;

   irq_prio_enc #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_enc (
      .masked_i (masked),
      .code_o   (code),
      .any_o    (ist)
   );

   irq_vec_port #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_vec (
      .clk    (clk),
      .rst_n  (rst_n),
      .ack_i  (ack_i),
      .code_i (code),
      .take_o (take),
      .oe_o   (vec_oe_o),
      .vec_o  (vec_o)
   );

   assign ien_cmd = ien_decode(ien_on_i, ien_off_i, take);

   always_ff @(posedge clk) begin
      if (!rst_n) ien_q <= 1'b0;
      else begin
         case (ien_cmd)
            IEN_RAISE: ien_q <= 1'b1;
            IEN_DROP:  ien_q <= 1'b0;
            default:   ien_q <= ien_q;
         endcase
      end
   end

   assign int_o = ien_q & ist;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int NUM_SRC = 4,
   parameter int BUS_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mask_wr_i,
   input logic [NUM_SRC-1:0] mask_wdata_i,
   input logic               ien_off_i,
   input logic               ack_i,
   input logic               int_o,
   input logic               vec_oe_o,
   input logic [BUS_W-1:0]   vec_o
);
   localparam int CODE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   AST_QUIET_IN_RESET: assert property (@(posedge clk) !rst_n |=> !vec_oe_o && vec_o == '0); // R1
   AST_MASK_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr_i && mask_wdata_i == '0 |=> !int_o); // R4
   AST_OFF_DROPS_INT: assert property (@(posedge clk) disable iff (!rst_n)
      ien_off_i |=> !int_o); // R7
   AST_TAKE_DROPS_INT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_i) |=> !int_o); // R8
   AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe_o && $past(vec_oe_o) |-> $stable(vec_o)); // R9
   AST_VEC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_o >> CODE_W) == '0); // R9
   AST_OE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe_o |-> $past(ack_i)); // R9
   AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |=> !vec_oe_o && vec_o == '0); // R10
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .BUS_W(BUS_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mask_wr_i    (mask_wr_i),
   .mask_wdata_i (mask_wdata_i),
   .ien_off_i    (ien_off_i),
   .ack_i        (ack_i),
   .int_o        (int_o),
   .vec_oe_o     (vec_oe_o),
   .vec_o        (vec_o)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
   localparam int N  = 4;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0, pclr = '0, mdat = '0;
   logic          mwr = 1'b0, on = 1'b0, off = 1'b0, ack = 1'b0;
   logic          int_o, oe;
   logic [BW-1:0] vec;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   prio_irq_ctrl #(.NUM_SRC(N), .BUS_W(BW)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .pend_clr_i(pclr),
      .mask_wr_i(mwr), .mask_wdata_i(mdat), .ien_on_i(on), .ien_off_i(off),
      .ack_i(ack), .int_o(int_o), .vec_oe_o(oe), .vec_o(vec)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle();
      pclr = '0; mwr = 1'b0; on = 1'b0; off = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   function automatic int first_set(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return 0;
   endfunction

   task automatic do_ack_check(input string tag, input int exp_code);
      ack = 1'b1; tick();
      chk({tag, " oe"}, 32'(oe), 1);
      chk({tag, " vec"}, 32'(vec), 32'(exp_code));
      ack = 1'b0; tick();
      chk("R10 oe released", 32'(oe), 0);
      chk("R10 vec zero", 32'(vec), 0);
   endtask

   initial begin
      #(4_000_000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      req = 4'b1111;
      tick(); tick();
      chk("R1 int after reset", 32'(int_o), 0);
      chk("R1 oe after reset", 32'(oe), 0);
      chk("R1 vec after reset", 32'(vec), 0);
      rst_n = 1'b1;
      tick();
      // pending bits set by the first rising edge seen, mask is zero
      chk("R1 mask starts zero", 32'(int_o), 0);
      mwr = 1'b1; mdat = 4'b1111; tick(); idle();
      chk("R1 ien starts zero", 32'(int_o), 0);
      on = 1'b1; tick(); idle();
      chk("R6 int raised", 32'(int_o), 1);
      req = '0; pclr = 4'b1111; tick(); idle();

      // R7: on and off together leave ien off
      req = 4'b0100; tick();
      on = 1'b1; off = 1'b1; tick(); idle();
      chk("R7 off wins", 32'(int_o), 0);
      on = 1'b1; tick(); idle();
      chk("R7 on sets", 32'(int_o), 1);
      off = 1'b1; tick(); idle();
      chk("R7 off clears", 32'(int_o), 0);

      // R8: acknowledge beats a simultaneous enable-on
      on = 1'b1; tick(); idle();
      on = 1'b1; ack = 1'b1; tick(); idle();
      chk("R8 take clears ien", 32'(int_o), 0);
      chk("R9 vec src2", 32'(vec), 2);
      ack = 1'b0; tick();
      req = '0; pclr = 4'b1111; tick(); idle();

      // R2: held-high source does not re-set after clear
      mwr = 1'b1; mdat = 4'b0010; req = 4'b0010; tick(); idle();
      on = 1'b1; tick(); idle();
      chk("R2 latched", 32'(int_o), 1);
      pclr = 4'b0010; tick(); idle();
      chk("R2 held high stays cleared", 32'(int_o), 0);
      req = '0; tick(); req = 4'b0010; tick();
      chk("R2 new edge sets", 32'(int_o), 1);
      req = '0; tick(); tick();
      chk("R2 stays after drop", 32'(int_o), 1);

      // R3: individual clear, and set wins over same-cycle clear
      pclr = 4'b1111; tick(); idle();
      mwr = 1'b1; mdat = 4'b1111; req = 4'b0011; tick(); idle();
      req = '0; pclr = 4'b0001; tick(); idle();
      on = 1'b1; tick(); idle();
      do_ack_check("R3 only src0 cleared", 1);
      pclr = 4'b1111; tick(); idle();
      mwr = 1'b1; mdat = 4'b0100; tick(); idle();
      req = 4'b0100; pclr = 4'b0100; tick(); idle();
      on = 1'b1; tick(); idle();
      chk("R3 set wins", 32'(int_o), 1);
      req = '0; pclr = 4'b1111; tick(); idle();

      // R9: vector held while new higher-priority request arrives
      mwr = 1'b1; mdat = 4'b1111; req = 4'b1000; tick(); idle();
      req = '0; ack = 1'b1; tick();
      chk("R9 captured src3", 32'(vec), 3);
      req = 4'b0001; tick();
      chk("R9 held after new req", 32'(vec), 3);
      tick();
      chk("R9 still held", 32'(vec), 3);
      chk("R9 oe held", 32'(oe), 1);
      req = '0; ack = 1'b0; tick();
      chk("R10 oe off", 32'(oe), 0);
      on = 1'b1; tick(); idle();
      do_ack_check("R9 new winner src0", 0);

      // R4 R5 R6: exhaustive sweep of pending and mask patterns
      for (int p = 0; p < 16; p++) begin
         for (int m = 0; m < 16; m++) begin
            logic [N-1:0] pv, mv, en;
            pv = 4'(p); mv = 4'(m); en = pv & mv;
            req = '0; pclr = '1; mwr = 1'b1; mdat = mv; tick(); idle();
            req = pv; on = 1'b1; tick(); idle();
            req = '0;
            chk($sformatf("R6 R4 int p=%0h m=%0h", p, m), 32'(int_o), 32'(|en));
            if (|en) begin
               ack = 1'b1; tick();
               chk($sformatf("R5 code p=%0h m=%0h", p, m), 32'(vec), 32'(first_set(en)));
               chk("R8 int low in ack", 32'(int_o), 0);
               ack = 1'b0; tick();
               chk("R10 oe low", 32'(oe), 0);
            end
         end
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule